// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Shift Engine

This block is a serial master for an EEPROM that sits on a three-wire bus: a serial clock, one bidirectional data line and a chip select. Firmware sets up a command by writing a control byte over a small register bus. That single write starts a burst of up to eight serial clocks. In a write command the burst shifts bits out of an 8-bit data register. In a read command it shifts bits from the EEPROM into that register. Each command carries its own bit count, its direction, a flag that releases the data line to high impedance when the burst ends, and a flag that delays the end of the command until the EEPROM reports that it is ready. A command with a count of zero issues no clocks and only sets the drive state of the data line.

The serial clock runs at `SCK_HZ` and is derived from `SYS_CLK_HZ`. Each phase of the clock lasts `SYS_CLK_HZ / (2*SCK_HZ)` system clocks, which is 4 with the default parameters. A busy flag can be read back through the bus. A one-cycle interrupt pulse marks the end of every command. The chip select is an ordinary register bit that firmware writes. The engine never changes it, and command sequencing is left to firmware.

The engine has five states, and the transitions between them are these:
- **IDLE** goes to **SCK_LO** when a command with a count of 1 or more is accepted.
- **IDLE** goes to **FINISH** when a zero-count command is accepted and the wait is not armed.
- **IDLE** goes to **WAIT_RDY** when a zero-count command is accepted and the wait is armed.
- **SCK_LO** goes to **SCK_HI** when the divider ticks. This is the rising edge of the serial clock.
- **SCK_HI** goes back to **SCK_LO** when the divider ticks and bits remain. This is the falling edge.
- **SCK_HI** goes to **FINISH** or **WAIT_RDY** when the divider ticks on the last bit.
- **WAIT_RDY** goes to **FINISH** on a rising edge of the data line.
- **FINISH** goes to **IDLE**, and the interrupt pulse follows.

Top module: `eeprom3w_master`

Register map. Each entry gives the value of `reg_addr` and what the register holds:
- `reg_addr` 0, control register:
  - bit 7: wait-for-ready flag
  - bit 6: busy (read-only)
  - bit 5: release flag (high impedance)
  - bit 4: read direction
  - bits 3:0: bit count
- `reg_addr` 1: data register.
- `reg_addr` 2: chip select, in bit 0.
- `reg_addr` 3: reads 0.

## Requirements
- R1: After reset the outputs and registers hold these values:
  - `busy` bit = 0, `sck` = 0, `sd_oe` = 1, `irq` = 0, `cs` = 0
  - data register = 0x00
- R2: A control write accepted while idle issues exactly the effective count of `sck` pulses. Each pulse is high for `HALF` system clocks, and `sck` idles low. A count field above 8 acts as 8, and it reads back as 8 in control bits 3:0.
- R3: In a write command (bit 4 = 0), bits leave MSB first from data bit 7. The data register shifts left with 0 fill on each falling edge. After N bits the register holds the original value shifted left by N.
- R4: In a read command (bit 4 = 1), `sd_in` is sampled at each rising edge of `sck` and shifted into bit 0. After N bits the low N bits hold the received bits MSB first, and the upper bits hold the original value shifted left by N.
- R5: In a write command with bit 5 = 1, `sd_oe` is 1 at every rising edge except the last one. It falls in the same cycle as that last rising edge and stays 0 afterwards. With bit 5 = 0, `sd_oe` stays 1.
- R6: In a read command with a count of 1 or more, `sd_oe` is 0 for the whole command and stays 0 after it ends.
- R7: With a count of 0, no `sck` pulse is issued and `sd_oe` becomes the inverse of bit 5. The command still ends with an interrupt pulse.
- R8: When both bit 7 and bit 5 are 1, busy stays high after the last pulse until a rising edge appears on `sd_in`. When bit 5 is 0, bit 7 has no effect.
- R9: Control bit 6 reads 1 while a command runs. `irq` is a single-cycle pulse, and it appears in the first cycle in which busy is low.
- R10: While busy, writes to the control register and to the data register are ignored.
- R11: `cs` follows bit 0 of writes to address 2 at any time, and the engine never changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| sck | output | 1 | Serial clock to EEPROM |
| sd_out | output | 1 | Serial data output value |
| sd_oe | output | 1 | Serial data output enable |
| sd_in | input | 1 | Serial data input from the pad |
| cs | output | 1 | Chip select, firmware controlled |
| irq | output | 1 | End-of-command interrupt pulse |

## Verification
The hardest state to reach is WAIT_RDY, which holds busy after the last clock while the line is released. To reach it, the bench keeps `sd_in` low through a full write burst that has both the release flag and the wait flag set. It then checks that busy still reads 1 and that no interrupt has appeared, and only after that raises `sd_in`. The read path needs an EEPROM model that changes `sd_in` on each falling edge of `sck`, so that the sampled bits can be compared against a known pattern.

// File: rtl/eep3w_pkg.sv
package eep3w_pkg;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned CNT_W    = 4;
    localparam int unsigned MAX_BITS = DATA_W;

    // control byte bit positions
    localparam int unsigned CTL_WFR  = 7;
    localparam int unsigned CTL_BUSY = 6;
    localparam int unsigned CTL_HIZ  = 5;
    localparam int unsigned CTL_RD   = 4;

    // register addresses
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_CS   = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCK_LO,
        ST_SCK_HI,
        ST_WAIT_RDY,
        ST_FINISH
    } eng_state_t;

    typedef struct packed {
        logic             wfr;
        logic             hiz;
        logic             rd;
        logic [CNT_W-1:0] cnt;
    } cmd_t;

    function automatic cmd_t decode_ctrl(input logic [DATA_W-1:0] b);
        cmd_t c;
        c.wfr = b[CTL_WFR];
        c.hiz = b[CTL_HIZ];
        c.rd  = b[CTL_RD];
        c.cnt = (b[CNT_W-1:0] > CNT_W'(MAX_BITS)) ? CNT_W'(MAX_BITS) : b[CNT_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/eep3w_clkdiv.sv
module eep3w_clkdiv #(
    parameter int unsigned HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int unsigned W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [W-1:0] RELOAD = W'(HALF - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else if (!run || cnt_q == '0) begin
            cnt_q <= RELOAD;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = run && (cnt_q == '0);

    p_tick_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == RELOAD));

endmodule

// File: rtl/eep3w_datareg.sv
module eep3w_datareg
    import eep3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift_en,
    input  logic              shift_in,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift_en) begin
            q <= {q[DATA_W-2:0], shift_in};
        end
    end

    p_no_load_during_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift_en));

endmodule

// File: rtl/eep3w_sdin_sync.sv
module eep3w_sdin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sd_in,
    output logic sd_s,
    output logic sd_rise
);

    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= sd_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sd_s    = sync_q;
    assign sd_rise = sync_q && !prev_q;

endmodule

// File: rtl/eep3w_engine.sv
module eep3w_engine
    import eep3w_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  cmd_t cmd_in,
    input  logic tick,
    input  logic sd_s,
    input  logic sd_rise,
    output logic busy,
    output logic sck,
    output logic sd_oe,
    output logic irq,
    output logic shift_en,
    output logic shift_in,
    output logic div_run,
    output cmd_t cmd_q
);

    eng_state_t       state, state_n;
    logic [CNT_W-1:0] bits_left;
    logic             sck_q, oe_q, irq_q;
    logic             last_bit, wait_armed_in, wait_armed_q;

    assign last_bit      = (bits_left == CNT_W'(1));
    assign wait_armed_in = cmd_in.wfr && cmd_in.hiz;
    assign wait_armed_q  = cmd_q.wfr && cmd_q.hiz;

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (cmd_in.cnt != '0)  state_n = ST_SCK_LO;
                    else if (wait_armed_in) state_n = ST_WAIT_RDY;
                    else                    state_n = ST_FINISH;
                end
            end
            ST_SCK_LO: begin
                if (tick) state_n = ST_SCK_HI;
            end
            ST_SCK_HI: begin
                if (tick) begin
                    if (!last_bit)         state_n = ST_SCK_LO;
                    else if (wait_armed_q) state_n = ST_WAIT_RDY;
                    else                   state_n = ST_FINISH;
                end
            end
            ST_WAIT_RDY: begin
                if (sd_rise) state_n = ST_FINISH;
            end
            ST_FINISH: begin
                state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // registered outputs and command context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q     <= 1'b0;
            oe_q      <= 1'b1;
            irq_q     <= 1'b0;
            bits_left <= '0;
            cmd_q     <= '0;
        end else begin
            sck_q <= (state_n == ST_SCK_HI);
            irq_q <= (state == ST_FINISH);
            if (state == ST_IDLE && start) begin
                cmd_q     <= cmd_in;
                bits_left <= cmd_in.cnt;
                oe_q      <= (cmd_in.cnt == '0) ? !cmd_in.hiz : !cmd_in.rd;
            end else begin
                if (state == ST_SCK_LO && tick && last_bit && cmd_q.hiz)
                    oe_q <= 1'b0;
                if (state == ST_SCK_HI && tick)
                    bits_left <= bits_left - 1'b1;
            end
        end
    end

    assign busy     = (state != ST_IDLE);
    assign sck      = sck_q;
    assign sd_oe    = oe_q;
    assign irq      = irq_q;
    assign div_run  = (state == ST_SCK_LO) || (state == ST_SCK_HI);
    assign shift_en = cmd_q.rd ? (state == ST_SCK_LO && tick) : (state == ST_SCK_HI && tick);
    assign shift_in = cmd_q.rd ? sd_s : 1'b0;

    p_irq_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    p_irq_at_busy_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!busy && $past(busy)));
    p_sck_low_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);
    p_bits_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bits_left <= CNT_W'(MAX_BITS));
    p_read_line_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_q.rd && cmd_q.cnt != '0) |-> !sd_oe);
    p_wait_only_when_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_RDY) |-> (cmd_q.hiz && cmd_q.wfr && !sd_oe));

endmodule

// File: rtl/eeprom3w_master.sv
module eeprom3w_master
    import eep3w_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ = 4_000_000,
    parameter int unsigned SCK_HZ     = 500_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       sck,
    output logic       sd_out,
    output logic       sd_oe,
    input  logic       sd_in,
    output logic       cs,
    output logic       irq
);

    localparam int unsigned HALF_RAW = SYS_CLK_HZ / (2 * SCK_HZ);
    localparam int unsigned HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;

    logic              busy, tick, div_run, shift_en, shift_in;
    logic              sd_s, sd_rise, cs_q;
    logic              ctrl_wr, data_wr, start;
    logic [DATA_W-1:0] data_q;
    cmd_t              cmd_q;

    assign ctrl_wr = reg_we && (reg_addr == ADDR_CTRL);
    assign data_wr = reg_we && (reg_addr == ADDR_DATA);
    assign start   = ctrl_wr && !busy;

    eep3w_clkdiv #(.HALF(HALF)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (div_run),
        .tick (tick)
    );

    eep3w_sdin_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sd_in  (sd_in),
        .sd_s   (sd_s),
        .sd_rise(sd_rise)
    );

    eep3w_datareg u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (data_wr && !busy),
        .load_val(reg_wdata),
        .shift_en(shift_en),
        .shift_in(shift_in),
        .q       (data_q)
    );

    eep3w_engine u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cmd_in  (decode_ctrl(reg_wdata)),
        .tick    (tick),
        .sd_s    (sd_s),
        .sd_rise (sd_rise),
        .busy    (busy),
        .sck     (sck),
        .sd_oe   (sd_oe),
        .irq     (irq),
        .shift_en(shift_en),
        .shift_in(shift_in),
        .div_run (div_run),
        .cmd_q   (cmd_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  cs_q <= 1'b0;
        else if (reg_we && reg_addr == ADDR_CS)      cs_q <= reg_wdata[0];
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = {cmd_q.wfr, busy, cmd_q.hiz, cmd_q.rd, cmd_q.cnt};
            ADDR_DATA: reg_rdata = data_q;
            ADDR_CS:   reg_rdata = {7'd0, cs_q};
            default:   reg_rdata = 8'd0;
        endcase
    end

    assign sd_out = data_q[DATA_W-1];
    assign cs     = cs_q;

    p_ctrl_ignored_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_wr) |=> $stable(cmd_q));
    p_data_ignored_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && data_wr && !shift_en) |=> $stable(data_q));
    p_cs_engine_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == ADDR_CS) |=> $stable(cs));

endmodule

// File: tb/eeprom3w_master_tb.sv
module eeprom3w_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       sck, sd_out, sd_oe, cs, irq;
    logic       sd_in = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // results of the last run_cmd
    int       r_pulses, r_hi_min, r_hi_max, r_oe_early_low, r_irq_w;
    logic [7:0] r_tx;
    logic     r_oe_last, r_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom3w_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .sd_out(sd_out),
        .sd_oe(sd_oe), .sd_in(sd_in), .cs(cs), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Issues a command and plays an EEPROM that presents rx bits MSB first,
    // changing sd_in after each falling sck edge.
    task automatic run_cmd(input logic [7:0] ctrl, input logic [7:0] rx, input int rx_n);
        int idx, hi, guard;
        logic prev;
        r_pulses = 0; r_hi_min = 1000; r_hi_max = 0; r_oe_early_low = 0;
        r_tx = 8'd0; r_oe_last = 1'b1; r_done = 1'b0; r_irq_w = 0;
        idx = rx_n - 1; hi = 0; prev = 1'b0; guard = 0;
        if (idx >= 0) sd_in = rx[idx];
        bus_write(2'd0, ctrl);
        while (!irq && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (sck && !prev) begin
                if (r_pulses > 0 && !r_oe_last) r_oe_early_low++;
                r_pulses++;
                r_tx = {r_tx[6:0], sd_out};
                r_oe_last = sd_oe;
            end
            if (sck) hi++;
            if (!sck && prev) begin
                if (hi < r_hi_min) r_hi_min = hi;
                if (hi > r_hi_max) r_hi_max = hi;
                hi = 0;
                idx--;
                if (idx >= 0) sd_in = rx[idx];
            end
            prev = sck;
        end
        if (irq) begin
            r_done = 1'b1;
            r_irq_w = 1;
            @(negedge clk);
            if (irq) r_irq_w++;
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 sck", sck, 0);
        chk("R1 sd_oe", sd_oe, 1);
        chk("R1 irq", irq, 0);
        chk("R1 cs", cs, 0);
        bus_read(2'd0, d); chk("R1 busy bit", d[6], 0);
        bus_read(2'd1, d); chk("R1 data", d, 8'h00);
    endtask

    task automatic t_write_full();
        logic [7:0] d;
        bus_write(2'd1, 8'hA5);
        run_cmd(8'h08, 8'h00, 0);
        chk("R2 pulses cnt8", r_pulses, 8);
        chk("R2 high width min", r_hi_min, HALF);
        chk("R2 high width max", r_hi_max, HALF);
        chk("R3 tx bits", r_tx, 8'hA5);
        chk("R5 oe kept hiz0", sd_oe, 1);
        chk("R9 irq seen", r_done, 1);
        chk("R9 irq width", r_irq_w, 1);
        chk("R2 sck idle", sck, 0);
        bus_read(2'd1, d); chk("R3 data after 8", d, 8'h00);
    endtask

    task automatic t_write_short();
        logic [7:0] d;
        bus_write(2'd1, 8'h6C);
        run_cmd(8'h03, 8'h00, 0);
        chk("R2 pulses cnt3", r_pulses, 3);
        chk("R3 tx 3 bits", r_tx, 8'h03);
        bus_read(2'd1, d); chk("R3 data after 3", d, 8'h60);
    endtask

    task automatic t_write_hiz();
        bus_write(2'd1, 8'hF0);
        run_cmd(8'h26, 8'h00, 0);
        chk("R2 pulses cnt6", r_pulses, 6);
        chk("R3 tx 6 bits", r_tx, 8'h3C);
        chk("R5 oe before last rise", r_oe_early_low, 0);
        chk("R5 oe at last rise", r_oe_last, 0);
        chk("R5 oe after", sd_oe, 0);
    endtask

    task automatic t_read();
        logic [7:0] d;
        bus_write(2'd1, 8'h00);
        run_cmd(8'h18, 8'hC3, 8);
        chk("R2 pulses read8", r_pulses, 8);
        chk("R6 oe at last rise", r_oe_last, 0);
        chk("R6 oe during read", r_oe_early_low, 7);
        chk("R6 oe after read", sd_oe, 0);
        bus_read(2'd1, d); chk("R4 read 8 bits", d, 8'hC3);
        bus_write(2'd1, 8'hFF);
        run_cmd(8'h05, 8'h16, 5);
        // bit 4 clear above would be a write; use a read command instead
        bus_write(2'd1, 8'hFF);
        run_cmd(8'h15, 8'h16, 5);
        chk("R2 pulses read5", r_pulses, 5);
        bus_read(2'd1, d); chk("R4 read 5 justified", d, 8'hF6);
    endtask

    task automatic t_zero();
        run_cmd(8'h20, 8'h00, 0);
        chk("R7 no pulse hiz1", r_pulses, 0);
        chk("R7 oe released", sd_oe, 0);
        chk("R7 irq hiz1", r_done, 1);
        run_cmd(8'h10, 8'h00, 0);
        chk("R7 no pulse rd bit", r_pulses, 0);
        chk("R7 oe retaken", sd_oe, 1);
        chk("R7 irq hiz0", r_done, 1);
    endtask

    task automatic t_saturate();
        logic [7:0] d;
        bus_write(2'd1, 8'h81);
        run_cmd(8'h0F, 8'h00, 0);
        chk("R2 pulses cnt15", r_pulses, 8);
        chk("R2 tx saturated", r_tx, 8'h81);
        bus_read(2'd0, d); chk("R2 cnt readback", d[3:0], 8);
    endtask

    task automatic t_wait_ready();
        logic [7:0] d;
        int seen, guard;
        sd_in = 1'b0;
        bus_write(2'd1, 8'h55);
        bus_write(2'd0, 8'hA8);
        seen = 0;
        repeat (2*HALF*8 + 20) begin
            @(negedge clk);
            if (irq) seen++;
        end
        chk("R8 no irq before ready", seen, 0);
        bus_read(2'd0, d); chk("R8 busy held", d[6], 1);
        chk("R8 line released", sd_oe, 0);
        sd_in = 1'b1;
        guard = 0;
        while (!irq && guard < 20) begin @(negedge clk); guard++; end
        chk("R8 irq after ready", irq, 1);
        @(negedge clk);
        sd_in = 1'b0;
        bus_read(2'd0, d); chk("R8 busy cleared", d[6], 0);
        // wait flag without release: ignored
        run_cmd(8'h88, 8'h00, 0);
        chk("R8 wfr ignored pulses", r_pulses, 8);
        chk("R8 wfr ignored ends", r_done, 1);
        chk("R8 wfr ignored oe", sd_oe, 1);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] d;
        int guard;
        bus_write(2'd1, 8'hA5);
        bus_write(2'd0, 8'h04);
        repeat (5) @(negedge clk);
        bus_read(2'd0, d); chk("R9 busy bit during cmd", d[6], 1);
        bus_write(2'd0, 8'h32);
        bus_write(2'd1, 8'hFF);
        guard = 0;
        while (!irq && guard < 500) begin @(negedge clk); guard++; end
        chk("R10 command ends", irq, 1);
        @(negedge clk);
        bus_read(2'd0, d); chk("R10 ctrl unchanged", d, 8'h04);
        bus_read(2'd1, d); chk("R10 data unchanged", d, 8'h50);
        chk("R10 oe unchanged", sd_oe, 1);
    endtask

    task automatic t_cs();
        logic [7:0] d;
        bus_write(2'd2, 8'h01);
        chk("R11 cs set", cs, 1);
        run_cmd(8'h02, 8'h00, 0);
        chk("R11 cs kept by engine", cs, 1);
        bus_read(2'd2, d); chk("R11 cs readback", d, 8'h01);
        bus_write(2'd2, 8'h00);
        chk("R11 cs cleared", cs, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_full();
        t_write_short();
        t_write_hiz();
        t_read();
        t_zero();
        t_saturate();
        t_wait_ready();
        t_busy_ignore();
        t_cs();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule